// File: doc/BRIEF.md
# Pixel Matrix Cluster Finder

This block keeps a cell-per-pixel copy of one sensor module region and sorts the fired pixels into connected groups. While the block is idle, hit addresses arrive one per clock as a row and a column. The matching cell is marked as hit. A module-end strobe then starts the grouping pass. A first priority network picks a seed hit, and selection spreads to every hit that touches it, one neighbour ring per clock, until no further cell changes. A second priority network then emits the selected pixels one per clock as row and column addresses. Each pixel is emptied as it leaves, and the final pixel of each group carries an end flag.

The pass repeats, one group after another, until the matrix holds nothing. A one-cycle done pulse then closes the module and the block returns to loading. The work grows with the number of hits and the group sizes, not with the number of hit pairs. The grid size is set by parameters, and the default is 16 rows by 8 columns.

Top module: `pixelClusterFinder`

## Requirements
- R1: After reset, outValid, outLast and done are low and every cell is empty, so a module-end strobe given right away produces no pixel output.
- R2: While idle, a hitValid cycle marks the pixel at (hitRow, hitCol) as hit. Writing the same pixel more than once still yields exactly one readout of it.
- R3: Two hits belong to the same group when their rows differ by at most 1 and their columns differ by at most 1, so touching along an edge or at a corner both count. Hits with a one-pixel gap between them form separate groups.
- R4: Groups are emitted in seed order. The seed is the hit in the lowest-numbered column that holds any hit, and the lowest row within that column, with row 0 at the top.
- R5: Within a group, pixels are emitted in ascending column and, within a column, in ascending row, on consecutive clock cycles with outValid high.
- R6: outLast is high together with outValid on exactly the final pixel of each group and on no other pixel.
- R7: Every loaded pixel is emitted exactly once and then cleared, so a further module-end strobe with no new hits produces no output.
- R8: done is a single-cycle pulse that follows the final pixel of the final group in the same cycle. For an empty matrix, done is high in the cycle right after the module-end strobe is sampled.
- R9: hitValid and moduleEnd are ignored while a grouping pass is running. A pixel offered during a pass is never stored.
- R10: The matrix edges do not wrap. A hit in row 0 and a hit in the last row are not neighbours, and neither are a hit in column 0 and a hit in the last column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hitValid | input | 1 | A hit address is present (idle only) |
| hitRow | input | ROW_W | Row of the incoming hit, 0 at the top |
| hitCol | input | COL_W | Column of the incoming hit, 0 at the left |
| moduleEnd | input | 1 | All hits of the module are loaded; starts grouping |
| outValid | output | 1 | An emitted pixel address is present |
| outRow | output | ROW_W | Row of the emitted pixel |
| outCol | output | COL_W | Column of the emitted pixel |
| outLast | output | 1 | The emitted pixel closes its group |
| done | output | 1 | One-cycle pulse: the matrix is empty |

## Verification
Several faults show up at the output stream within the group they affect. A cell stuck selected or stuck hit makes the same pixel appear twice or never, or leaves a residue that a later empty module-end pass emits. A wrong neighbour mask splits or merges groups, which moves the outLast flags within a few cycles of the first emitted pixel. A wrong priority direction reorders addresses from the first output onward, and a control fault that loads while busy leaks an extra pixel into the next module's stream.

// File: rtl/pixClusterPkg.sv
package pixClusterPkg;

  typedef enum logic [1:0] {
    CELL_EMPTY = 2'b00,
    CELL_HIT   = 2'b01,
    CELL_SEL   = 2'b10
  } cellState_e;

  typedef enum logic [1:0] {
    CTL_IDLE,
    CTL_SEED,
    CTL_GROW,
    CTL_READ
  } ctlState_e;

  // Strobes from control to the cell array
  typedef struct packed {
    logic load;
    logic seed;
    logic grow;
    logic read;
  } matrixStrobe_t;

endpackage

// File: rtl/pixCell.sv
module pixCell
  import pixClusterPkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loadHit,
  input  logic seedHit,
  input  logic grow,
  input  logic nbrSel,
  input  logic clearSel,
  output logic isHit,
  output logic isSel
);

  cellState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      CELL_EMPTY: if (loadHit) stateNext = CELL_HIT;
      CELL_HIT:   if (seedHit || (grow && nbrSel)) stateNext = CELL_SEL;
      CELL_SEL:   if (clearSel) stateNext = CELL_EMPTY;
      default:    stateNext = CELL_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= CELL_EMPTY;
    else        state <= stateNext;
  end

  assign isHit = (state == CELL_HIT);
  assign isSel = (state == CELL_SEL);

  // An empty cell can only become a hit, never jump to selected
  p_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CELL_EMPTY) |=> (state != CELL_SEL));

endmodule

// File: rtl/clusterMatrix.sv
module clusterMatrix
  import pixClusterPkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  matrixStrobe_t     strb,
  input  logic [ROW_W-1:0]  hitRow,
  input  logic [COL_W-1:0]  hitCol,
  output logic              anyHit,
  output logic              anySel,
  output logic              anyGrow,
  output logic              lastSel,
  output logic              outValid,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol,
  output logic              outLast
);

  localparam int NCELL = ROWS * COLS;

  logic [NCELL-1:0] hitVec, selVec, nbrVec;
  logic [NCELL-1:0] seedOneHot, readOneHot;
  logic [ROW_W-1:0] readRow;
  logic [COL_W-1:0] readCol;

  // Cell index is column-major: idx = col*ROWS + row, so the lowest set
  // bit is the leftmost column, topmost row.
  assign seedOneHot = hitVec & (~hitVec + 1'b1);
  assign readOneHot = selVec & (~selVec + 1'b1);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int IDX = c * ROWS + r;
      logic addrMatch;
      assign addrMatch = (int'(hitRow) == r) && (int'(hitCol) == c);
      pixCell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .loadHit  (strb.load && addrMatch),
        .seedHit  (strb.seed && seedOneHot[IDX]),
        .grow     (strb.grow),
        .nbrSel   (nbrVec[IDX]),
        .clearSel (strb.read && readOneHot[IDX]),
        .isHit    (hitVec[IDX]),
        .isSel    (selVec[IDX])
      );
    end
  end

  // Eight-neighbour OR of the selected flags, no wrap at the borders
  always_comb begin
    nbrVec = '0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int dc = -1; dc <= 1; dc++) begin
          for (int dr = -1; dr <= 1; dr++) begin
            if (!(dc == 0 && dr == 0) &&
                (c + dc >= 0) && (c + dc < COLS) &&
                (r + dr >= 0) && (r + dr < ROWS)) begin
              nbrVec[c*ROWS + r] = nbrVec[c*ROWS + r] |
                                   selVec[(c+dc)*ROWS + (r+dr)];
            end
          end
        end
      end
    end
  end

  // Address encoder for the readout winner
  always_comb begin
    readRow = '0;
    readCol = '0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        if (readOneHot[c*ROWS + r]) begin
          readRow = readRow | ROW_W'(r);
          readCol = readCol | COL_W'(c);
        end
      end
    end
  end

  assign anyHit  = |hitVec;
  assign anySel  = |selVec;
  assign anyGrow = |(hitVec & nbrVec);
  assign lastSel = $onehot(selVec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outRow   <= '0;
      outCol   <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= strb.read;
      outLast  <= strb.read && lastSel;
      if (strb.read) begin
        outRow <= readRow;
        outCol <= readCol;
      end
    end
  end

  p_read_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.read |-> anySel);

  p_read_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.read |=> ($countones(selVec) == $countones($past(selVec)) - 1));

  p_seed_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.seed |-> (!anySel && anyHit));

  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outLast |-> outValid);

endmodule

// File: rtl/clusterCtrl.sv
module clusterCtrl
  import pixClusterPkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hitValid,
  input  logic          moduleEnd,
  input  logic          anyHit,
  input  logic          anySel,
  input  logic          anyGrow,
  input  logic          lastSel,
  output matrixStrobe_t strb,
  output logic          done
);

  ctlState_e state, stateNext;
  logic      doneNext;

  always_comb begin
    stateNext = state;
    doneNext  = 1'b0;
    strb      = '0;
    unique case (state)
      CTL_IDLE: begin
        strb.load = hitValid;
        if (moduleEnd) begin
          if (anyHit || hitValid) stateNext = CTL_SEED;
          else                    doneNext  = 1'b1;
        end
      end
      CTL_SEED: begin
        strb.seed = 1'b1;
        stateNext = CTL_GROW;
      end
      CTL_GROW: begin
        strb.grow = 1'b1;
        if (!anyGrow) stateNext = CTL_READ;
      end
      CTL_READ: begin
        strb.read = 1'b1;
        if (lastSel) begin
          if (anyHit) stateNext = CTL_SEED;
          else begin
            stateNext = CTL_IDLE;
            doneNext  = 1'b1;
          end
        end
      end
      default: stateNext = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CTL_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  p_done_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!anyHit && !anySel));

  p_read_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.read && !lastSel) |=> strb.read);

endmodule

// File: rtl/pixelClusterFinder.sv
module pixelClusterFinder
  import pixClusterPkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hitValid,
  input  logic [ROW_W-1:0] hitRow,
  input  logic [COL_W-1:0] hitCol,
  input  logic             moduleEnd,
  output logic             outValid,
  output logic [ROW_W-1:0] outRow,
  output logic [COL_W-1:0] outCol,
  output logic             outLast,
  output logic             done
);

  matrixStrobe_t strb;
  logic anyHit, anySel, anyGrow, lastSel;

  clusterCtrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hitValid  (hitValid),
    .moduleEnd (moduleEnd),
    .anyHit    (anyHit),
    .anySel    (anySel),
    .anyGrow   (anyGrow),
    .lastSel   (lastSel),
    .strb      (strb),
    .done      (done)
  );

  clusterMatrix #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_matrix (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .hitRow   (hitRow),
    .hitCol   (hitCol),
    .anyHit   (anyHit),
    .anySel   (anySel),
    .anyGrow  (anyGrow),
    .lastSel  (lastSel),
    .outValid (outValid),
    .outRow   (outRow),
    .outCol   (outCol),
    .outLast  (outLast)
  );

endmodule

// File: tb/pixelClusterFinder_bench.sv
module pixelClusterFinder_bench;

  localparam int ROWS  = 16;
  localparam int COLS  = 8;
  localparam int ROW_W = 4;
  localparam int COL_W = 3;
  localparam int NC    = ROWS * COLS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hitValid = 1'b0;
  logic [ROW_W-1:0] hitRow = '0;
  logic [COL_W-1:0] hitCol = '0;
  logic             moduleEnd = 1'b0;
  logic             outValid, outLast, done;
  logic [ROW_W-1:0] outRow;
  logic [COL_W-1:0] outCol;

  int checks = 0;
  int fails  = 0;

  bit [NC-1:0] model;
  int expR [NC];
  int expC [NC];
  int expL [NC];
  int expN;
  int gotR [NC];
  int gotC [NC];
  int gotL [NC];
  int gotN;

  always #2.5 clk = ~clk;

  pixelClusterFinder u_pixelClusterFinder (
    .clk       (clk),
    .rst_n     (rst_n),
    .hitValid  (hitValid),
    .hitRow    (hitRow),
    .hitCol    (hitCol),
    .moduleEnd (moduleEnd),
    .outValid  (outValid),
    .outRow    (outRow),
    .outCol    (outCol),
    .outLast   (outLast),
    .done      (done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic loadHit(input int r, input int c);
    @(negedge clk);
    hitValid = 1'b1;
    hitRow   = ROW_W'(r);
    hitCol   = COL_W'(c);
    model[c*ROWS + r] = 1'b1;
    @(negedge clk);
    hitValid = 1'b0;
  endtask

  function automatic bit touches(input int a, input int b);
    int ra = a % ROWS, ca = a / ROWS, rb = b % ROWS, cb = b / ROWS;
    int dr = ra - rb, dc = ca - cb;
    return (a != b) && dr <= 1 && dr >= -1 && dc <= 1 && dc >= -1;
  endfunction

  // Expected stream from the requirement text: seed = lowest column-major
  // index, grow by 8-neighbour touch, emit members column-major.
  task automatic buildExpected();
    bit [NC-1:0] left = model;
    bit [NC-1:0] grp;
    bit changed;
    int lastIdx;
    expN = 0;
    while (left != '0) begin
      grp = '0;
      for (int i = 0; i < NC; i++) if (left[i]) begin grp[i] = 1'b1; break; end
      changed = 1'b1;
      while (changed) begin
        changed = 1'b0;
        for (int j = 0; j < NC; j++)
          if (left[j] && !grp[j])
            for (int k = 0; k < NC; k++)
              if (grp[k] && touches(j, k) && !grp[j]) begin
                grp[j] = 1'b1;
                changed = 1'b1;
              end
      end
      lastIdx = 0;
      for (int j = 0; j < NC; j++) if (grp[j]) lastIdx = j;
      for (int j = 0; j < NC; j++) if (grp[j]) begin
        expR[expN] = j % ROWS;
        expC[expN] = j / ROWS;
        expL[expN] = (j == lastIdx) ? 1 : 0;
        expN++;
      end
      left &= ~grp;
    end
  endtask

  task automatic runPass(input string tag, input bit inject,
                         input int injR, input int injC);
    int doneAt = -1;
    buildExpected();
    model = '0;
    gotN  = 0;
    @(negedge clk);
    moduleEnd = 1'b1;
    @(negedge clk);
    moduleEnd = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      if (outValid && gotN < NC) begin
        gotR[gotN] = int'(outRow);
        gotC[gotN] = int'(outCol);
        gotL[gotN] = int'(outLast);
        gotN++;
      end
      if (!outValid && outLast) check(1'b0, tag, "outLast without outValid", 1, 0);
      if (done) begin doneAt = k; break; end
      if (inject && k == 1) begin
        hitValid  = 1'b1;
        hitRow    = ROW_W'(injR);
        hitCol    = COL_W'(injC);
        moduleEnd = 1'b1;
      end else begin
        hitValid  = 1'b0;
        moduleEnd = 1'b0;
      end
      @(negedge clk);
    end
    hitValid  = 1'b0;
    moduleEnd = 1'b0;
    check(doneAt >= 0, tag, "done seen", doneAt, 0);
    check(gotN == expN, tag, "pixel count", gotN, expN);
    for (int i = 0; i < expN; i++) begin
      if (i < gotN) begin
        check(gotR[i] == expR[i], tag, $sformatf("row of pixel %0d", i), gotR[i], expR[i]);
        check(gotC[i] == expC[i], tag, $sformatf("col of pixel %0d", i), gotC[i], expC[i]);
        check(gotL[i] == expL[i], tag, $sformatf("last of pixel %0d", i), gotL[i], expL[i]);
      end
    end
    if (expN == 0)
      check(doneAt == 0, tag, "done latency on empty matrix", doneAt, 0);
    @(negedge clk);
    check(done == 1'b0, tag, "done width", int'(done), 0);
    check(outValid == 1'b0, tag, "outValid after done", int'(outValid), 0);
  endtask

  task automatic testReset();
    repeat (3) begin
      @(negedge clk);
      check(!outValid && !outLast && !done, "R1", "outputs after reset",
            int'({outValid, outLast, done}), 0);
    end
    runPass("R1", 1'b0, 0, 0);
  endtask

  task automatic testDuplicate();
    loadHit(5, 3);
    loadHit(5, 3);
    loadHit(5, 3);
    runPass("R2", 1'b0, 0, 0);
  endtask

  task automatic testTouch();
    loadHit(2, 1); loadHit(3, 2); loadHit(4, 3); loadHit(4, 4);
    loadHit(10, 5); loadHit(12, 5);
    loadHit(7, 6); loadHit(7, 7);
    runPass("R3", 1'b0, 0, 0);
  endtask

  task automatic testSeedOrder();
    loadHit(3, 6); loadHit(9, 2); loadHit(1, 2); loadHit(14, 0);
    runPass("R4", 1'b0, 0, 0);
  endtask

  task automatic testBlob();
    for (int c = 2; c <= 4; c++)
      for (int r = 4; r <= 6; r++) loadHit(r, c);
    loadHit(7, 5); loadHit(8, 6); loadHit(0, 0);
    runPass("R5", 1'b0, 0, 0);
    runPass("R7", 1'b0, 0, 0);
  endtask

  task automatic testLastFlags();
    loadHit(0, 1); loadHit(1, 1); loadHit(6, 1); loadHit(6, 3); loadHit(5, 4);
    runPass("R6", 1'b0, 0, 0);
  endtask

  task automatic testEmpty();
    runPass("R8", 1'b0, 0, 0);
  endtask

  task automatic testBusy();
    loadHit(2, 2); loadHit(3, 3); loadHit(4, 4);
    runPass("R9", 1'b1, 12, 6);
    runPass("R9", 1'b0, 0, 0);
  endtask

  task automatic testEdges();
    loadHit(0, 0); loadHit(15, 0); loadHit(0, 7); loadHit(15, 7); loadHit(15, 1);
    runPass("R10", 1'b0, 0, 0);
  endtask

  initial begin
    model = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testDuplicate();
    testTouch();
    testSeedOrder();
    testBlob();
    testLastFlags();
    testEmpty();
    testBusy();
    testEdges();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule